// File: doc/BRIEF.md
# Processor event entry and vectoring unit

This block sits beside a simple in-order pipeline and decides which pending event the core services next. Each pipeline stage reports a set of event flags for the instruction it holds: debug request, memory-protection violation, translation miss, supervisor call and external interrupt. Reset is handled as the strongest event of all. The unit chooses one winner and computes the handler fetch address from an event base address, a fixed per-cause offset or, for interrupts, an autovector offset supplied by an interrupt controller. It also produces the return address and status word to be saved, and the updated status word.

The winner is chosen by age first. The oldest instruction that carries any event is serviced, whatever a younger instruction carries. Only then does a fixed priority among that instruction's own events apply. Debug entry saves the return context in two dedicated return registers held inside the unit. A return-from-debug request restores that context. Supervisor calls instead raise a strobe that pushes the return context onto the system stack. All results are registered and appear together with a one-cycle redirect pulse and a flush mask for the pipeline stages.

Top module: `evt_vector_unit`

## Requirements
- R1: While `rst` is high, every output is zero. On the first clock edge with `rst` low, the unit emits one redirect to 0x80000000 with cause 1 (reset) and `flush` all ones, and raises no save or status strobe. Events present in that cycle are dropped.
- R2: Stage index `s` carries flags at `ev_flags[s*5 +: 5]` and PC at `stage_pc[s*32 +: 32]`, and a higher index is an older instruction. The oldest stage with any unmasked flag wins even when a younger stage has a higher-priority event. `flush` sets the bits of the winning stage and of every younger stage.
- R3: Within one stage, the flag bits are bit 0 debug, bit 1 protection, bit 2 miss, bit 3 supervisor call and bit 4 interrupt. The lowest set bit wins. Causes are encoded as 2 debug, 3 protection, 4 miss, 5 supervisor call, 6 interrupt, 7 debug return and 0 none.
- R4: When `sr_in` bit 29 (debug mask) is set, debug flags are ignored. Other flags on the same or other stages then compete as if the debug flag were absent, and a lone debug flag produces no redirect.
- R5: Debug entry targets `evba`+0x1C. It raises `save_dbg` but not `push_stack`. `save_pc` is the stage PC, `save_sr` is `sr_in`, and `sr_out` is `sr_in` with bit 30 (debug state) set.
- R6: Protection and miss events target `evba`+0x10 and `evba`+0x50. `save_pc` is the stage PC, and `sr_out` is `sr_in` with bit 16 (event mask) set. The same status update applies to supervisor calls and interrupts.
- R7: A supervisor call targets `evba`+0x100 and raises `push_stack`. Its `save_pc` is the stage PC plus 2.
- R8: An interrupt targets `evba` plus the 14-bit `autovec` zero-extended, which allows offsets up to 0x3FFF. Its `save_pc` is the stage PC.
- R9: A `retd_req` with no unmasked event redirects to the PC saved at the last debug entry, with `sr_out` equal to the saved status, cause 7 and `flush` all ones. The saved pair is zero after reset. When an event is present, the event is serviced and `retd_req` is ignored.
- R10: Every result appears one clock edge after the inputs are sampled. `redirect` is high for one cycle per serviced event. `sr_wr` accompanies every redirect except the reset redirect. In a cycle with no redirect, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_flags | input | NSTAGES*5 | Per-stage event flags |
| stage_pc | input | NSTAGES*XLEN | Per-stage instruction PC |
| evba | input | XLEN | Event base address |
| autovec | input | AVW | Interrupt autovector offset |
| sr_in | input | XLEN | Current status word |
| retd_req | input | 1 | Return-from-debug request |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| target_pc | output | XLEN | Handler or return fetch address |
| flush | output | NSTAGES | Stages to squash |
| push_stack | output | 1 | Push save_pc/save_sr to system stack |
| save_dbg | output | 1 | Context written to debug return registers |
| save_pc | output | XLEN | Return address to save |
| save_sr | output | XLEN | Status word to save |
| sr_wr | output | 1 | Load sr_out into status register |
| sr_out | output | XLEN | New status word |
| cause | output | 3 | Serviced cause code |

## Verification
Every result is due on the clock edge after the one that samples its inputs. The reset redirect is due on the first edge that sees `rst` low. A debug return uses the context written by the debug entry serviced in any earlier cycle, including the immediately preceding one. The bench drives inputs on the falling edge and forecasts the outputs from those inputs just after the rising edge. It then compares every output on the next falling edge, so each forecast lines up with exactly one register stage.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NKIND = 5;
  localparam int K_DBG   = 0;
  localparam int K_PROT  = 1;
  localparam int K_MISS  = 2;
  localparam int K_SCALL = 3;
  localparam int K_IRQ   = 4;

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_RESET = 3'd1;
  localparam logic [2:0] C_DBG   = 3'd2;
  localparam logic [2:0] C_PROT  = 3'd3;
  localparam logic [2:0] C_MISS  = 3'd4;
  localparam logic [2:0] C_SCALL = 3'd5;
  localparam logic [2:0] C_IRQ   = 3'd6;
  localparam logic [2:0] C_RETD  = 3'd7;
endpackage

// File: rtl/evt_stage_pick.sv
module evt_stage_pick
  import evt_pkg::*;
(
  input  logic [NKIND-1:0] flags,
  input  logic             dbg_mask,
  output logic             hit,
  output logic [2:0]       sel
);
  logic [NKIND-1:0] eff;

  always_comb begin
    eff        = flags;
    eff[K_DBG] = flags[K_DBG] & ~dbg_mask;
    hit        = |eff;
    // later assignments override earlier ones: strongest last
    sel = C_NONE;
    if (eff[K_IRQ])   sel = C_IRQ;
    if (eff[K_SCALL]) sel = C_SCALL;
    if (eff[K_MISS])  sel = C_MISS;
    if (eff[K_PROT])  sel = C_PROT;
    if (eff[K_DBG])   sel = C_DBG;
  end
endmodule

// File: rtl/evt_age_arb.sv
module evt_age_arb #(
  parameter  int NS = 3,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] hit,
  output logic          any,
  output logic [SW-1:0] win,
  output logic [NS-1:0] squash
);
  always_comb begin
    any = |hit;
    win = '0;
    // higher index is older, so the last hit found wins
    for (int i = 0; i < NS; i++) begin
      if (hit[i]) win = SW'(i);
    end
    for (int i = 0; i < NS; i++) begin
      squash[i] = any && (SW'(i) <= win);
    end
  end
endmodule

// File: rtl/evt_dbg_regs.sv
module evt_dbg_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] sr_in,
  output logic [XLEN-1:0] ret_pc,
  output logic [XLEN-1:0] ret_sr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_pc <= '0;
      ret_sr <= '0;
    end else if (wr) begin
      ret_pc <= pc_in;
      ret_sr <= sr_in;
    end
  end
endmodule

// File: rtl/evt_vector_unit.sv
module evt_vector_unit
  import evt_pkg::*;
#(
  parameter int              NSTAGES   = 3,
  parameter int              XLEN      = 32,
  parameter int              AVW       = 14,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h8000_0000,
  parameter logic [XLEN-1:0] OFF_DBG   = 32'h0000_001C,
  parameter logic [XLEN-1:0] OFF_PROT  = 32'h0000_0010,
  parameter logic [XLEN-1:0] OFF_MISS  = 32'h0000_0050,
  parameter logic [XLEN-1:0] OFF_SCALL = 32'h0000_0100,
  parameter logic [XLEN-1:0] SCALL_LEN = 32'h0000_0002,
  parameter int              SR_D_BIT  = 30,
  parameter int              SR_DM_BIT = 29,
  parameter int              SR_XM_BIT = 16,
  localparam int             SW        = (NSTAGES > 1) ? $clog2(NSTAGES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSTAGES*NKIND-1:0] ev_flags,
  input  logic [NSTAGES*XLEN-1:0]  stage_pc,
  input  logic [XLEN-1:0]          evba,
  input  logic [AVW-1:0]           autovec,
  input  logic [XLEN-1:0]          sr_in,
  input  logic                     retd_req,
  output logic                     redirect,
  output logic [XLEN-1:0]          target_pc,
  output logic [NSTAGES-1:0]       flush,
  output logic                     push_stack,
  output logic                     save_dbg,
  output logic [XLEN-1:0]          save_pc,
  output logic [XLEN-1:0]          save_sr,
  output logic                     sr_wr,
  output logic [XLEN-1:0]          sr_out,
  output logic [2:0]               cause
);
  logic [NSTAGES-1:0] st_hit;
  logic [2:0]         st_sel [NSTAGES];
  logic               any_c;
  logic [SW-1:0]      win_c;
  logic [NSTAGES-1:0] squash_c;
  logic [2:0]         cause_c;
  logic [XLEN-1:0]    pc_c, tgt_c, ret_c, sr_c;
  logic [XLEN-1:0]    rar, rsr;
  logic               rst_pend;
  logic               dbg_wr;

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    evt_stage_pick u_pick (
      .flags    (ev_flags[s*NKIND +: NKIND]),
      .dbg_mask (sr_in[SR_DM_BIT]),
      .hit      (st_hit[s]),
      .sel      (st_sel[s])
    );
  end

  evt_age_arb #(.NS(NSTAGES)) u_arb (
    .hit    (st_hit),
    .any    (any_c),
    .win    (win_c),
    .squash (squash_c)
  );

  always_comb begin
    cause_c = st_sel[win_c];
    pc_c    = stage_pc[int'(win_c)*XLEN +: XLEN];
    ret_c   = (cause_c == C_SCALL) ? pc_c + SCALL_LEN : pc_c;
    case (cause_c)
      C_DBG:   tgt_c = evba + OFF_DBG;
      C_PROT:  tgt_c = evba + OFF_PROT;
      C_MISS:  tgt_c = evba + OFF_MISS;
      C_SCALL: tgt_c = evba + OFF_SCALL;
      default: tgt_c = evba + {{(XLEN-AVW){1'b0}}, autovec};
    endcase
    if (cause_c == C_DBG) sr_c = sr_in | (XLEN'(1) << SR_D_BIT);
    else                  sr_c = sr_in | (XLEN'(1) << SR_XM_BIT);
  end

  assign dbg_wr = !rst && !rst_pend && any_c && (cause_c == C_DBG);

  evt_dbg_regs #(.XLEN(XLEN)) u_dbg (
    .clk    (clk),
    .rst    (rst),
    .wr     (dbg_wr),
    .pc_in  (ret_c),
    .sr_in  (sr_in),
    .ret_pc (rar),
    .ret_sr (rsr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend   <= 1'b1;
      redirect   <= 1'b0;
      target_pc  <= '0;
      flush      <= '0;
      push_stack <= 1'b0;
      save_dbg   <= 1'b0;
      save_pc    <= '0;
      save_sr    <= '0;
      sr_wr      <= 1'b0;
      sr_out     <= '0;
      cause      <= C_NONE;
    end else begin
      redirect   <= 1'b0;
      target_pc  <= '0;
      flush      <= '0;
      push_stack <= 1'b0;
      save_dbg   <= 1'b0;
      save_pc    <= '0;
      save_sr    <= '0;
      sr_wr      <= 1'b0;
      sr_out     <= '0;
      cause      <= C_NONE;
      if (rst_pend) begin
        rst_pend  <= 1'b0;
        redirect  <= 1'b1;
        target_pc <= RESET_PC;
        flush     <= '1;
        cause     <= C_RESET;
      end else if (any_c) begin
        redirect   <= 1'b1;
        target_pc  <= tgt_c;
        flush      <= squash_c;
        cause      <= cause_c;
        save_pc    <= ret_c;
        save_sr    <= sr_in;
        sr_out     <= sr_c;
        sr_wr      <= 1'b1;
        push_stack <= (cause_c == C_SCALL);
        save_dbg   <= (cause_c == C_DBG);
      end else if (retd_req) begin
        redirect  <= 1'b1;
        target_pc <= rar;
        sr_out    <= rsr;
        sr_wr     <= 1'b1;
        flush     <= '1;
        cause     <= C_RETD;
      end
    end
  end
endmodule

// File: rtl/evt_vector_unit_chk.sv
module evt_vector_unit_chk
  import evt_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              AVW       = 14,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h8000_0000,
  parameter int              SR_D_BIT  = 30,
  parameter int              SR_DM_BIT = 29
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] evba,
  input logic [AVW-1:0]  autovec,
  input logic [XLEN-1:0] sr_in,
  input logic            redirect,
  input logic [XLEN-1:0] target_pc,
  input logic            push_stack,
  input logic            save_dbg,
  input logic            sr_wr,
  input logic [XLEN-1:0] sr_out,
  input logic [2:0]      cause
);
  p_reset_vector_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (redirect && target_pc == RESET_PC && cause == C_RESET && !sr_wr));

  p_dbg_needs_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    (redirect && cause == C_DBG) |-> !$past(sr_in[SR_DM_BIT]));

  p_dbg_sets_state_r5: assert property (@(posedge clk) disable iff (rst)
    save_dbg |-> (sr_out[SR_D_BIT] && !push_stack && cause == C_DBG));

  p_push_only_scall_r7: assert property (@(posedge clk) disable iff (rst)
    push_stack |-> (redirect && cause == C_SCALL));

  p_irq_target_r8: assert property (@(posedge clk) disable iff (rst)
    (redirect && cause == C_IRQ) |->
      (target_pc == $past(evba) + {{(XLEN-AVW){1'b0}}, $past(autovec)}));

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> (!push_stack && !save_dbg && !sr_wr && cause == C_NONE));
endmodule

bind evt_vector_unit evt_vector_unit_chk #(
  .XLEN(XLEN), .AVW(AVW), .RESET_PC(RESET_PC),
  .SR_D_BIT(SR_D_BIT), .SR_DM_BIT(SR_DM_BIT)
) u_chk (
  .clk(clk), .rst(rst), .evba(evba), .autovec(autovec), .sr_in(sr_in),
  .redirect(redirect), .target_pc(target_pc), .push_stack(push_stack),
  .save_dbg(save_dbg), .sr_wr(sr_wr), .sr_out(sr_out), .cause(cause)
);

// File: tb/evt_vector_unit_test.sv
`timescale 1ns/1ps
module evt_vector_unit_test;
  localparam int NS = 3;
  localparam int XL = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [NS*5-1:0] ev_flags;
  logic [NS*XL-1:0] stage_pc;
  logic [XL-1:0]   evba;
  logic [13:0]     autovec;
  logic [XL-1:0]   sr_in;
  logic            retd_req;
  logic            redirect, push_stack, save_dbg, sr_wr;
  logic [XL-1:0]   target_pc, save_pc, save_sr, sr_out;
  logic [NS-1:0]   flush;
  logic [2:0]      cause;

  always #2.5 clk = ~clk;

  evt_vector_unit uut (
    .clk(clk), .rst(rst), .ev_flags(ev_flags), .stage_pc(stage_pc),
    .evba(evba), .autovec(autovec), .sr_in(sr_in), .retd_req(retd_req),
    .redirect(redirect), .target_pc(target_pc), .flush(flush),
    .push_stack(push_stack), .save_dbg(save_dbg), .save_pc(save_pc),
    .save_sr(save_sr), .sr_wr(sr_wr), .sr_out(sr_out), .cause(cause)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_pend;
  logic [31:0] m_rar, m_rsr;
  logic [31:0] e_tgt, e_spc, e_ssr, e_sro;
  logic [2:0]  e_cause, e_flush;
  bit          e_red, e_push, e_dbg, e_srw;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int win;
    int kind;
    logic [4:0] f;
    logic [31:0] pc;
    e_red = 0; e_tgt = 0; e_flush = 0; e_cause = 0; e_push = 0; e_dbg = 0;
    e_spc = 0; e_ssr = 0; e_srw = 0; e_sro = 0;
    if (rst) begin
      m_pend = 1; m_rar = 0; m_rsr = 0;
      return;
    end
    if (m_pend) begin
      m_pend = 0; e_red = 1; e_tgt = 32'h8000_0000; e_flush = 3'b111; e_cause = 1;
      return;
    end
    win = -1; kind = -1;
    for (int s = NS - 1; s >= 0 && win < 0; s--) begin
      f = ev_flags[s*5 +: 5];
      if (sr_in[29]) f[0] = 1'b0;
      for (int k = 0; k < 5 && kind < 0; k++) if (f[k]) kind = k;
      if (kind >= 0) win = s;
    end
    if (win >= 0) begin
      pc = stage_pc[win*32 +: 32];
      e_red = 1; e_cause = 3'(kind + 2); e_srw = 1; e_ssr = sr_in; e_spc = pc;
      for (int i = 0; i < NS; i++) e_flush[i] = (i <= win);
      e_sro = sr_in | 32'h0001_0000;
      case (kind)
        0: begin e_tgt = evba + 32'h1C; e_dbg = 1; e_sro = sr_in | 32'h4000_0000; end
        1: e_tgt = evba + 32'h10;
        2: e_tgt = evba + 32'h50;
        3: begin e_tgt = evba + 32'h100; e_push = 1; e_spc = pc + 2; end
        default: e_tgt = evba + {18'd0, autovec};
      endcase
      if (kind == 0) begin m_rar = e_spc; m_rsr = sr_in; end
    end else if (retd_req) begin
      e_red = 1; e_tgt = m_rar; e_sro = m_rsr; e_srw = 1; e_flush = 3'b111; e_cause = 7;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #1 model();
    @(negedge clk);
    chk(tag, "redirect", 32'(redirect), 32'(e_red));
    chk(tag, "target_pc", target_pc, e_tgt);
    chk(tag, "flush", 32'(flush), 32'(e_flush));
    chk(tag, "cause", 32'(cause), 32'(e_cause));
    chk(tag, "push_stack", 32'(push_stack), 32'(e_push));
    chk(tag, "save_dbg", 32'(save_dbg), 32'(e_dbg));
    chk(tag, "save_pc", save_pc, e_spc);
    chk(tag, "save_sr", save_sr, e_ssr);
    chk(tag, "sr_wr", 32'(sr_wr), 32'(e_srw));
    chk(tag, "sr_out", sr_out, e_sro);
  endtask

  function automatic logic [NS*5-1:0] fl(input int s, input logic [4:0] k);
    return (NS*5)'(k) << (s*5);
  endfunction

  initial begin
    rst = 1; ev_flags = 0; retd_req = 0; autovec = 0;
    evba = 32'h0010_0000; sr_in = 32'h0000_0003;
    stage_pc = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
    @(negedge clk);
    ev_flags = fl(2, 5'b00010);          // must be ignored under reset
    step("R1"); step("R1");
    rst = 0;
    step("R1");                          // reset redirect, event dropped
    ev_flags = 0;
    step("R10");                         // idle
    ev_flags = fl(0, 5'b10000); autovec = 14'h3FFF;
    step("R8");
    autovec = 14'h0040; ev_flags = fl(1, 5'b10000);
    step("R8");
    ev_flags = fl(1, 5'b00010); step("R6");
    ev_flags = fl(2, 5'b00100); step("R6");
    ev_flags = fl(1, 5'b11111); sr_in = 32'h0000_0005;
    step("R5");                          // debug wins in-stage, saved
    ev_flags = fl(1, 5'b01110); step("R3");
    ev_flags = fl(0, 5'b11100); step("R3");
    ev_flags = fl(2, 5'b11000); step("R7");
    ev_flags = fl(0, 5'b00001) | fl(2, 5'b10000); step("R2");
    ev_flags = fl(0, 5'b00010) | fl(1, 5'b01000); step("R2");
    sr_in = 32'h2000_0000;
    ev_flags = fl(2, 5'b00001); step("R4");
    ev_flags = fl(1, 5'b10001); step("R4");
    ev_flags = fl(2, 5'b00001) | fl(0, 5'b00010); step("R4");
    ev_flags = 0; retd_req = 1; sr_in = 32'h0;
    step("R9");                          // return to saved debug context
    ev_flags = fl(0, 5'b01000); step("R9");   // event wins over retd
    ev_flags = fl(2, 5'b00001); evba = 32'h0020_0000; step("R5");
    ev_flags = 0; step("R9");            // uses context saved one cycle ago
    retd_req = 0; step("R10");
    ev_flags = fl(0, 5'b10000); step("R10");
    ev_flags = fl(1, 5'b10000); step("R10");  // back-to-back pulses
    ev_flags = 0; step("R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule